// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves received Ethernet frames from a byte stream into memory. Software sets up a ring of two-word descriptors, each pointing at one buffer, and gives the block the ring's base address. For every frame the block fetches the descriptor at its current ring position over a single-beat memory port. It packs the frame bytes into 32-bit words and writes them into the buffer. It then writes a status word and hands the descriptor back to software by setting its ownership flag.

A frame longer than one buffer continues into the following descriptors. The first buffer of a frame is flagged as the start and the buffer holding the final byte is flagged as the end. A descriptor whose last-entry flag is set sends the ring position back to the base. When the block finds a descriptor still owned by software, it discards the rest of the frame and increments an overrun counter. Frames that arrive while receive is disabled are discarded without any memory traffic.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset no memory request is active and the overrun count is zero.
- R2: A descriptor is 8 bytes. Word 0 holds the buffer address in bits 31:2, the last-entry flag in bit 1 and the ownership flag in bit 0 (1 = filled by the block, 0 = free for the block). Word 1 is the status word. Descriptor n lies at base + 8*n, and bits 2:0 of the base input are ignored.
- R3: Byte k of a buffer lands at buffer address + k, in bits 8*(k mod 4)+7 : 8*(k mod 4) of its word (little-endian). Unused byte lanes of a final partial word are written as zero, and no word beyond the byte count rounded up to a whole word is written.
- R4: After a buffer is filled, word 1 is written first, with the byte count in bits 13:0, bit 14 = this buffer holds the frame's first byte, bit 15 = this buffer holds its last byte, and all other bits zero. Word 0 is written after it, with the buffer address and last-entry flag unchanged and the ownership flag set.
- R5: A frame longer than BUF_BYTES fills consecutive descriptors. Every buffer except the last holds exactly BUF_BYTES bytes.
- R6: After a descriptor with the last-entry flag is used, the next descriptor taken is the one at the base.
- R7: If the descriptor fetched for a frame's first byte is owned (bit 0 = 1), the frame is discarded, no descriptor or buffer is written, the overrun count increases by one, and the ring position stays at that descriptor.
- R8: If a continuation descriptor is owned, the buffers already filled stay handed back, the remaining bytes of the frame are discarded, the overrun count increases by one, and the ring position stays at the owned descriptor.
- R9: A frame whose first byte arrives while rx_enable is low is discarded whole, with no memory access and no change to the overrun count.
- R10: A pulse on base_load sets the ring position to the base.
- R11: A memory request holds its address, direction and write data stable until it is acknowledged, and every address is word aligned.
- R12: The overrun count changes only by +1, and only in the cycle after an owned descriptor was read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receive enable, sampled at each frame's first byte |
| ring_base | input | 32 | Ring base address |
| base_load | input | 1 | Pulse: return ring position to ring_base |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted when high together with s_valid |
| s_data | input | 8 | Stream byte |
| s_sof | input | 1 | Byte is the first of a frame |
| s_eof | input | 1 | Byte is the last of a frame |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request completed |
| overrun_count | output | OVR_W | Frames cut short or dropped because a descriptor was owned |

## Verification
The bench targets frames of exactly one buffer, one byte past a buffer, and a single byte. A design that got the full-buffer test wrong would open an empty extra descriptor or run past the buffer end. A design that got the partial word wrong would leave stale bytes in unused lanes. The bench also wraps the ring at the last-entry descriptor and meets owned descriptors both at a frame's start and in its middle. A design wrong there would overwrite buffers software still holds, miscount overruns, or move the ring position. Disabled receive, a base reload in the middle of the ring, and descriptor words written out of order are checked as well. Each of these would show up as an unexpected descriptor or buffer word in memory.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int LEN_W      = 14;
    localparam int DESC_BYTES = 8;
    localparam int OWN_POS    = 0;
    localparam int LAST_POS   = 1;
    localparam int SOF_POS    = 14;
    localparam int EOF_POS    = 15;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_FILL,
        ST_WDATA,
        ST_WSTAT,
        ST_WDESC,
        ST_DROP
    } rxr_state_e;
endpackage

// File: rtl/rxr_lane_merge.sv
module rxr_lane_merge (
    input  logic [31:0] cur_word,
    input  logic [1:0]  lane,
    input  logic [7:0]  byte_in,
    output logic [31:0] merged
);
    for (genvar l = 0; l < 4; l++) begin : g_lane
        always_comb begin
            if (lane == 2'(l))
                merged[8*l +: 8] = byte_in;
            else if (lane > 2'(l))
                merged[8*l +: 8] = cur_word[8*l +: 8];
            else
                merged[8*l +: 8] = 8'h00;
        end
    end
endmodule

// File: rtl/rxr_desc_codec.sv
module rxr_desc_codec
    import rxr_pkg::*;
(
    input  logic [31:0]      fetched,
    output logic [31:0]      fetched_buf,
    output logic             fetched_last,
    output logic             fetched_own,
    input  logic [31:0]      buf_addr,
    input  logic             last_entry,
    output logic [31:0]      release_word,
    input  logic [LEN_W-1:0] count,
    input  logic             has_sof,
    input  logic             has_eof,
    output logic [31:0]      status_word
);
    always_comb begin
        fetched_buf  = fetched & ~32'h3;
        fetched_last = fetched[LAST_POS];
        fetched_own  = fetched[OWN_POS];

        release_word           = buf_addr & ~32'h3;
        release_word[LAST_POS] = last_entry;
        release_word[OWN_POS]  = 1'b1;

        status_word            = '0;
        status_word[LEN_W-1:0] = count;
        status_word[SOF_POS]   = has_sof;
        status_word[EOF_POS]   = has_eof;
    end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int BUF_BYTES = 1536,
    parameter int OVR_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_enable,
    input  logic [31:0]      ring_base,
    input  logic             base_load,
    input  logic             s_valid,
    output logic             s_ready,
    input  logic [7:0]       s_data,
    input  logic             s_sof,
    input  logic             s_eof,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_ack,
    output logic [OVR_W-1:0] overrun_count
);
    localparam logic [LEN_W-1:0] BUF_LEN  = LEN_W'(BUF_BYTES);
    localparam logic [LEN_W-1:0] BUF_LAST = LEN_W'(BUF_BYTES - 1);

    typedef struct packed {
        rxr_state_e       st;
        logic [31:0]      desc_ptr;
        logic [31:0]      buf_addr;
        logic             last_entry;
        logic [LEN_W-1:0] cnt;
        logic [31:0]      word;
        logic             sof_buf;
        logic             eof_seen;
        logic [OVR_W-1:0] ovr;
    } regs_t;

    regs_t r_d, r_q;

    logic [31:0]      base_al;
    logic [31:0]      merged;
    logic [31:0]      f_buf, rel_word, stat_word, word_off;
    logic             f_last, f_own;
    logic [LEN_W-1:0] cnt_m1;

    assign base_al = ring_base & ~32'h7;
    assign cnt_m1  = r_q.cnt - 1'b1;
    assign word_off = 32'(cnt_m1 & ~LEN_W'(3));

    rxr_lane_merge u_merge (
        .cur_word (r_q.word),
        .lane     (r_q.cnt[1:0]),
        .byte_in  (s_data),
        .merged   (merged)
    );

    rxr_desc_codec u_codec (
        .fetched      (mem_rdata),
        .fetched_buf  (f_buf),
        .fetched_last (f_last),
        .fetched_own  (f_own),
        .buf_addr     (r_q.buf_addr),
        .last_entry   (r_q.last_entry),
        .release_word (rel_word),
        .count        (r_q.cnt),
        .has_sof      (r_q.sof_buf),
        .has_eof      (r_q.eof_seen),
        .status_word  (stat_word)
    );

    always_comb begin
        r_d       = r_q;
        s_ready   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (r_q.st)
            ST_IDLE: begin
                if (s_valid) begin
                    if (s_sof && rx_enable) begin
                        r_d.st       = ST_FETCH;
                        r_d.sof_buf  = 1'b1;
                        r_d.eof_seen = 1'b0;
                    end else begin
                        s_ready = 1'b1;
                        if (s_sof && !s_eof) r_d.st = ST_DROP;
                    end
                end
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = r_q.desc_ptr;
                if (mem_ack) begin
                    if (f_own) begin
                        r_d.ovr = r_q.ovr + 1'b1;
                        r_d.st  = ST_DROP;
                    end else begin
                        r_d.buf_addr   = f_buf;
                        r_d.last_entry = f_last;
                        r_d.cnt        = '0;
                        r_d.st         = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                s_ready = 1'b1;
                if (s_valid) begin
                    r_d.word     = merged;
                    r_d.cnt      = r_q.cnt + 1'b1;
                    r_d.eof_seen = s_eof;
                    if (r_q.cnt[1:0] == 2'd3 || s_eof || r_q.cnt == BUF_LAST)
                        r_d.st = ST_WDATA;
                end
            end
            ST_WDATA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.buf_addr + word_off;
                mem_wdata = r_q.word;
                if (mem_ack)
                    r_d.st = (r_q.eof_seen || r_q.cnt == BUF_LEN) ? ST_WSTAT : ST_FILL;
            end
            ST_WSTAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.desc_ptr + 32'd4;
                mem_wdata = stat_word;
                if (mem_ack) r_d.st = ST_WDESC;
            end
            ST_WDESC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.desc_ptr;
                mem_wdata = rel_word;
                if (mem_ack) begin
                    r_d.desc_ptr = r_q.last_entry ? base_al : r_q.desc_ptr + 32'(DESC_BYTES);
                    r_d.sof_buf  = 1'b0;
                    r_d.st       = r_q.eof_seen ? ST_IDLE : ST_FETCH;
                end
            end
            ST_DROP: begin
                s_ready = 1'b1;
                if (s_valid && s_eof) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
        if (base_load) r_d.desc_ptr = base_al;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign overrun_count = r_q.ovr;
endmodule

// File: rtl/rxr_checker.sv
module rxr_checker #(
    parameter int OVR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_req,
    input logic             mem_we,
    input logic [31:0]      mem_addr,
    input logic [31:0]      mem_wdata,
    input logic [31:0]      mem_rdata,
    input logic             mem_ack,
    input logic [OVR_W-1:0] overrun_count
);
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R11
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);

    // R7
    owned_fetch_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack && !mem_we && mem_rdata[0] |=> overrun_count == $past(overrun_count) + 1'b1);

    // R12
    ovr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(overrun_count) |-> overrun_count == $past(overrun_count) + 1'b1);

    // R12
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(overrun_count) |-> $past(mem_req && mem_ack && !mem_we && mem_rdata[0]));
endmodule

bind rx_ring_writer rxr_checker #(.OVR_W(OVR_W)) u_rxr_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_rdata     (mem_rdata),
    .mem_ack       (mem_ack),
    .overrun_count (overrun_count)
);

// File: tb/rx_ring_writer_test.sv
`timescale 1ns/1ps
module rx_ring_writer_test;
    localparam int          BUF     = 16;
    localparam int          NDESC   = 4;
    localparam logic [31:0] BASE    = 32'h1000;
    localparam logic [31:0] BUFBASE = 32'h2000;
    localparam logic [31:0] BSTRIDE = 32'h40;
    localparam logic [31:0] PATTERN = 32'hDEADBEEF;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rx_enable = 1'b0, base_load = 1'b0;
    logic [31:0] ring_base = '0;
    logic s_valid = 1'b0, s_sof = 1'b0, s_eof = 1'b0;
    logic [7:0] s_data = '0;
    logic s_ready, mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic mem_ack = 1'b0;
    logic [15:0] overrun_count;

    int n_chk = 0, n_fail = 0;
    int exp_idx = 0, exp_ovr = 0;
    logic [31:0] mem [int unsigned];
    logic [31:0] expm [int unsigned];
    logic [31:0] prev_wr = '0;
    logic [7:0] frame [64];

    always #2 clk = ~clk;

    rx_ring_writer #(.BUF_BYTES(BUF), .OVR_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .ring_base(ring_base),
        .base_load(base_load), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .s_sof(s_sof), .s_eof(s_eof), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .overrun_count(overrun_count)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    function automatic bit is_desc(input logic [31:0] a);
        return a >= BASE && a < BASE + 32'(8 * NDESC);
    endfunction

    function automatic bit in_region(input logic [31:0] a);
        return is_desc(a) || (a >= BUFBASE && a < BUFBASE + NDESC * BSTRIDE);
    endfunction

    // memory responder with random latency
    initial begin
        int dly = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                if (dly > 0) dly--;
                else begin
                    chk("R11", "aligned in-ring address", {31'b0, in_region(mem_addr) && mem_addr[1:0] == 2'b00}, 32'd1);
                    if (mem_we) begin
                        if (is_desc(mem_addr)) begin
                            chk("R7", "write to owned descriptor", {31'b0, mem[mem_addr & ~32'h7][0]}, 32'd0);
                            if (mem_addr[2] == 1'b0)
                                chk("R4", "status written before word 0", prev_wr, mem_addr + 32'd4);
                        end
                        mem[mem_addr] = mem_wdata;
                        prev_wr = mem_addr;
                    end else begin
                        mem_rdata = mem[mem_addr];
                    end
                    mem_ack = 1'b1;
                    dly = int'($urandom % 3);
                end
            end
        end
    end

    task automatic init_ring();
        for (int i = 0; i < NDESC; i++) begin
            logic [31:0] w0;
            w0 = BUFBASE + 32'(i) * BSTRIDE;
            if (i == NDESC - 1) w0 = w0 | 32'h2;
            mem[BASE + 32'(8*i)] = w0;       expm[BASE + 32'(8*i)] = w0;
            mem[BASE + 32'(8*i) + 4] = '0;   expm[BASE + 32'(8*i) + 4] = '0;
            for (int j = 0; j < 16; j++) begin
                mem[BUFBASE + 32'(i) * BSTRIDE + 32'(4*j)]  = PATTERN;
                expm[BUFBASE + 32'(i) * BSTRIDE + 32'(4*j)] = PATTERN;
            end
        end
    endtask

    task automatic free_desc(input int i);
        mem[BASE + 32'(8*i)]  = mem[BASE + 32'(8*i)] & ~32'h1;
        expm[BASE + 32'(8*i)] = expm[BASE + 32'(8*i)] & ~32'h1;
    endtask

    task automatic predict(input int len, input bit en);
        int rem, k, idx;
        bit first;
        if (!en) return;
        rem = len; k = 0; idx = exp_idx; first = 1'b1;
        while (rem > 0) begin
            logic [31:0] w0, ba, st;
            int n;
            w0 = expm[BASE + 32'(8*idx)];
            if (w0[0]) begin
                exp_ovr++;
                break;
            end
            n = (rem < BUF) ? rem : BUF;
            ba = w0 & ~32'h3;
            for (int j = 0; j < (n + 3) / 4; j++) begin
                logic [31:0] v;
                v = '0;
                for (int l = 0; l < 4; l++)
                    if (4*j + l < n) v[8*l +: 8] = frame[k + 4*j + l];
                expm[ba + 32'(4*j)] = v;
            end
            st = 32'(n);
            st[14] = first;
            st[15] = (rem == n);
            expm[BASE + 32'(8*idx) + 4] = st;
            expm[BASE + 32'(8*idx)] = w0 | 32'h1;
            idx = w0[1] ? 0 : idx + 1;
            rem -= n; k += n; first = 1'b0;
        end
        exp_idx = idx;
    endtask

    task automatic send(input int len);
        for (int k = 0; k < len; k++) begin
            s_valid = 1'b1; s_data = frame[k];
            s_sof = (k == 0); s_eof = (k == len - 1);
            while (1) begin
                #1;
                if (s_ready) break;
                @(negedge clk);
            end
            @(negedge clk);
        end
        s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
    endtask

    task automatic quiet();
        int c = 0;
        while (c < 8) begin
            @(negedge clk);
            if (mem_req) c = 0; else c++;
        end
    endtask

    task automatic compare_all(input string tag);
        foreach (expm[a]) chk(tag, $sformatf("word at %h", a), mem[a], expm[a]);
        chk("R12", "overrun count", 32'(overrun_count), 32'(exp_ovr));
    endtask

    task automatic run(input int len, input bit en, input string tag);
        for (int k = 0; k < len; k++) frame[k] = 8'($urandom);
        rx_enable = en;
        predict(len, en);
        send(len);
        quiet();
        compare_all(tag);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        init_ring();
        repeat (3) @(negedge clk);
        chk("R1", "mem_req in reset", {31'b0, mem_req}, 32'd0);
        chk("R1", "overrun in reset", 32'(overrun_count), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "mem_req after reset", {31'b0, mem_req}, 32'd0);
        ring_base = BASE | 32'h5;
        base_load = 1'b1;
        @(negedge clk);
        base_load = 1'b0;
        exp_idx = 0;

        run(1, 1'b1, "R2");
        run(16, 1'b1, "R4");
        run(17, 1'b1, "R5");
        run(5, 1'b1, "R7");
        free_desc(0);
        run(3, 1'b1, "R6");
        free_desc(1);
        run(20, 1'b1, "R8");
        for (int i = 0; i < NDESC; i++) free_desc(i);
        run(8, 1'b0, "R9");
        base_load = 1'b1;
        @(negedge clk);
        base_load = 1'b0;
        exp_idx = 0;
        run(6, 1'b1, "R10");
        run(11, 1'b1, "R3");

        for (int it = 0; it < 30; it++) begin
            for (int i = 0; i < NDESC; i++)
                if ($urandom % 4 != 0) free_desc(i);
            run(1 + int'($urandom % 40), ($urandom % 10) != 0, "R5");
        end

        summary();
        $finish;
    end
endmodule